// File: doc/BRIEF.md
# Hierarchical carry look-ahead adder tree

This block adds two binary words by means of a look-ahead carry tree. The operands are cut into narrow adder slices. Each slice reports whether it generates a carry on its own and whether it would pass an incoming carry through. A four-way look-ahead cell works out, from those reports and one carry input, the carries into three of its groups at once. It also forms a combined generate/propagate pair for the group as a whole. The same cell is reused at every level of the tree, inside each slice as well, so any width that is a multiple of the slice width can be covered with a few levels of logic.

Generate, propagate and the combined group outputs of every cell are active-low. All carries are active-high. A cell does not produce the carry out of its last group. At the top of the tree that carry is formed from the combined group pair and the carry input. A mode parameter picks between two arrangements. One is full look-ahead, where cells are stacked until a single cell covers the word. The other uses look-ahead inside blocks of four slices and ripples the carry from block to block. The whole block is combinational, with no clock and no state.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of a + b + cin.
- R2: `cout` equals bit WIDTH of a + b + cin, the carry out of the whole word.
- R3: `grp_prop_n` is 0 exactly when every bit position has a and b different, so that (a XOR b) is all ones; otherwise it is 1.
- R4: `grp_gen_n` is 0 exactly when a + b with a carry input of 0 overflows WIDTH bits; otherwise it is 1.
- R5: `cout` equals (NOT grp_gen_n) OR ((NOT grp_prop_n) AND cin) for every input.
- R6: When a XOR b is all ones, a carry input of 1 gives sum all zeros with cout 1, and a carry input of 0 gives sum all ones with cout 0.
- R7: In block-ripple mode (look-ahead inside four-slice blocks, ripple between blocks) R1 to R5 hold unchanged.
- R8: At a width of 32 bits the top cell sees only two groups. R1 to R5 still hold there, with the unused cell inputs tied so that they neither generate nor block propagation.
- R9: The four-way cell, with active-low group inputs g_n[i] and p_n[i] (index 0 the least significant group) and active-high carry input c, gives carry[k-1] = OR over j<k of (g[j] AND p[j+1..k-1]) OR (p[0..k-1] AND c) for k = 1..3. It gives grp_g_n = NOT(OR over j<4 of g[j] AND p[j+1..3]) and grp_p_n = NOT(AND of p[0..3]), where g = NOT g_n and p = NOT p_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into the least significant bit |
| sum | output | WIDTH | Low WIDTH bits of the sum |
| cout | output | 1 | Carry out of the most significant bit |
| grp_gen_n | output | 1 | Active-low: the word generates a carry by itself |
| grp_prop_n | output | 1 | Active-low: the word passes an incoming carry through |

## Verification
The bound checker compares sum, carry out and both active-low group outputs with a plain wide addition whenever an input changes, for every instance and in both modes. This covers the arithmetic and the group polarity for every vector applied. Other behaviour is visible only through the bench's chosen scenarios. That includes the carry running the full length of an all-propagate word, the tied-off inputs of the partly used top cell at 32 bits, and the exact sum-of-products form and polarity of the single cell, which the bench drives through all 512 input patterns.

// File: rtl/cla_pkg.sv
package cla_pkg;

  typedef enum logic [0:0] {
    TREE_FULL         = 1'b0,
    TREE_BLOCK_RIPPLE = 1'b1
  } tree_mode_e;

  // groups left after folding n groups by radix r, lvl times
  function automatic int group_count(input int n, input int r, input int lvl);
    int c;
    c = n;
    for (int i = 0; i < lvl; i++) c = (c + r - 1) / r;
    return c;
  endfunction

  // levels of cells needed until a single group remains (at least one)
  function automatic int level_count(input int n, input int r);
    int c;
    int l;
    c = n;
    l = 0;
    while (c > 1) begin
      c = (c + r - 1) / r;
      l++;
    end
    if (l == 0) l = 1;
    return l;
  endfunction

endpackage

// File: rtl/cla_cell.sv
module cla_cell #(
  parameter int RADIX = 4
) (
  input  logic [RADIX-1:0] g_n,
  input  logic [RADIX-1:0] p_n,
  input  logic             c_in,
  output logic [RADIX-2:0] carry,
  output logic             grp_g_n,
  output logic             grp_p_n
);

  logic [RADIX-1:0] gen;
  logic [RADIX-1:0] prop;

  assign gen  = ~g_n;
  assign prop = ~p_n;

  // OR over j<top of gen[j] AND every prop above j and below top
  function automatic logic span_gen(input logic [RADIX-1:0] g,
                                    input logic [RADIX-1:0] p,
                                    input int top);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < RADIX; j++) begin
      if (j < top) begin
        term = g[j];
        for (int m = 0; m < RADIX; m++) begin
          if (m > j && m < top) term = term & p[m];
        end
        acc = acc | term;
      end
    end
    return acc;
  endfunction

  // AND of prop[0 .. top-1]
  function automatic logic span_prop(input logic [RADIX-1:0] p, input int top);
    logic acc;
    acc = 1'b1;
    for (int m = 0; m < RADIX; m++) begin
      if (m < top) acc = acc & p[m];
    end
    return acc;
  endfunction

  always_comb begin
    for (int k = 1; k < RADIX; k++) begin
      carry[k-1] = span_gen(gen, prop, k) | (span_prop(prop, k) & c_in);
    end
    grp_g_n = ~span_gen(gen, prop, RADIX);
    grp_p_n = ~span_prop(prop, RADIX);
  end

endmodule

// File: rtl/cla_slice.sv
module cla_slice #(
  parameter int BITS = 4
) (
  input  logic [BITS-1:0] a,
  input  logic [BITS-1:0] b,
  input  logic            c_in,
  output logic [BITS-1:0] sum,
  output logic            g_n,
  output logic            p_n
);

  logic [BITS-1:0] bit_gen;
  logic [BITS-1:0] bit_prop;
  logic [BITS-2:0] inner_c;
  logic [BITS-1:0] bit_c;

  assign bit_gen  = a & b;
  assign bit_prop = a ^ b;

  cla_cell #(.RADIX(BITS)) i_bit_cell (
    .g_n     (~bit_gen),
    .p_n     (~bit_prop),
    .c_in    (c_in),
    .carry   (inner_c),
    .grp_g_n (g_n),
    .grp_p_n (p_n)
  );

  assign bit_c = {inner_c, c_in};
  assign sum   = bit_prop ^ bit_c;

endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int                  WIDTH      = 64,
  parameter int                  SLICE_BITS = 4,
  parameter int                  RADIX      = 4,
  parameter cla_pkg::tree_mode_e MODE       = cla_pkg::TREE_FULL
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             grp_gen_n,
  output logic             grp_prop_n
);

  localparam int NSLICE = WIDTH / SLICE_BITS;

  logic [NSLICE-1:0] sl_g_n;
  logic [NSLICE-1:0] sl_p_n;
  logic [NSLICE-1:0] sl_c;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    cla_slice #(.BITS(SLICE_BITS)) i_slice (
      .a    (a[s*SLICE_BITS +: SLICE_BITS]),
      .b    (b[s*SLICE_BITS +: SLICE_BITS]),
      .c_in (sl_c[s]),
      .sum  (sum[s*SLICE_BITS +: SLICE_BITS]),
      .g_n  (sl_g_n[s]),
      .p_n  (sl_p_n[s])
    );
  end

  if (MODE == cla_pkg::TREE_FULL) begin : g_full
    localparam int NLVL = cla_pkg::level_count(NSLICE, RADIX);

    // level 0 holds slice groups, level NLVL the single word group
    logic [NLVL:0][NSLICE-1:0] tg_n;
    logic [NLVL:0][NSLICE-1:0] tp_n;
    logic [NLVL:0][NSLICE-1:0] tc;

    assign tg_n[0] = sl_g_n;
    assign tp_n[0] = sl_p_n;
    assign sl_c    = tc[0];
    assign tc[NLVL][0] = cin;

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      localparam int IN_CNT  = cla_pkg::group_count(NSLICE, RADIX, l);
      localparam int OUT_CNT = cla_pkg::group_count(NSLICE, RADIX, l + 1);
      for (genvar k = 0; k < NSLICE; k++) begin : g_node
        if (k < OUT_CNT) begin : g_used
          logic [RADIX-1:0] cg_n;
          logic [RADIX-1:0] cp_n;
          logic [RADIX-2:0] cc;
          logic             og_n;
          logic             op_n;
          for (genvar j = 0; j < RADIX; j++) begin : g_in
            localparam int IDX = k * RADIX + j;
            if (IDX < IN_CNT) begin : g_real
              assign cg_n[j] = tg_n[l][IDX];
              assign cp_n[j] = tp_n[l][IDX];
              if (j == 0) begin : g_first
                assign tc[l][IDX] = tc[l+1][k];
              end else begin : g_inner
                assign tc[l][IDX] = cc[j-1];
              end
            end else begin : g_pad
              // absent group: never generates, never blocks
              assign cg_n[j] = 1'b1;
              assign cp_n[j] = 1'b0;
            end
          end
          cla_cell #(.RADIX(RADIX)) i_cell (
            .g_n     (cg_n),
            .p_n     (cp_n),
            .c_in    (tc[l+1][k]),
            .carry   (cc),
            .grp_g_n (og_n),
            .grp_p_n (op_n)
          );
          assign tg_n[l+1][k] = og_n;
          assign tp_n[l+1][k] = op_n;
        end else begin : g_unused
          assign tg_n[l+1][k] = 1'b1;
          assign tp_n[l+1][k] = 1'b0;
          assign tc[l+1][k]   = 1'b0;
        end
      end
    end

    assign grp_gen_n  = tg_n[NLVL][0];
    assign grp_prop_n = tp_n[NLVL][0];
    assign cout       = ~tg_n[NLVL][0] | (~tp_n[NLVL][0] & cin);

  end else begin : g_ripple
    localparam int NBLK = (NSLICE + RADIX - 1) / RADIX;

    logic [NBLK:0] blk_c;
    logic [NBLK:0] gen_acc;
    logic [NBLK:0] prop_acc;

    assign blk_c[0]    = cin;
    assign gen_acc[0]  = 1'b0;
    assign prop_acc[0] = 1'b1;

    for (genvar k = 0; k < NBLK; k++) begin : g_blk
      logic [RADIX-1:0] cg_n;
      logic [RADIX-1:0] cp_n;
      logic [RADIX-2:0] cc;
      logic             bg_n;
      logic             bp_n;
      for (genvar j = 0; j < RADIX; j++) begin : g_in
        localparam int IDX = k * RADIX + j;
        if (IDX < NSLICE) begin : g_real
          assign cg_n[j] = sl_g_n[IDX];
          assign cp_n[j] = sl_p_n[IDX];
          if (j == 0) begin : g_first
            assign sl_c[IDX] = blk_c[k];
          end else begin : g_inner
            assign sl_c[IDX] = cc[j-1];
          end
        end else begin : g_pad
          assign cg_n[j] = 1'b1;
          assign cp_n[j] = 1'b0;
        end
      end
      cla_cell #(.RADIX(RADIX)) i_cell (
        .g_n     (cg_n),
        .p_n     (cp_n),
        .c_in    (blk_c[k]),
        .carry   (cc),
        .grp_g_n (bg_n),
        .grp_p_n (bp_n)
      );
      // carry into the next block is formed outside the cell
      assign blk_c[k+1]    = ~bg_n | (~bp_n & blk_c[k]);
      assign gen_acc[k+1]  = ~bg_n | (~bp_n & gen_acc[k]);
      assign prop_acc[k+1] = prop_acc[k] & ~bp_n;
    end

    assign cout       = blk_c[NBLK];
    assign grp_gen_n  = ~gen_acc[NBLK];
    assign grp_prop_n = ~prop_acc[NBLK];
  end

endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int WIDTH = 64
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic             grp_gen_n,
  input logic             grp_prop_n
);

  logic [WIDTH:0] ref_full;
  logic [WIDTH:0] ref_zero;

  always_comb begin
    ref_full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    ref_zero = {1'b0, a} + {1'b0, b};
    a_r1_sum_matches: assert (sum == ref_full[WIDTH-1:0])
      else $error("R1 sum mismatch");
    a_r2_carry_out: assert (cout == ref_full[WIDTH])
      else $error("R2 carry out mismatch");
    a_r3_group_prop: assert (grp_prop_n == ~(&(a ^ b)))
      else $error("R3 group propagate mismatch");
    a_r4_group_gen: assert (grp_gen_n == ~ref_zero[WIDTH])
      else $error("R4 group generate mismatch");
  end

endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) i_cla_adder_chk (.*);

// File: tb/test_cla_adder.sv
module test_cla_adder;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [63:0] ta  = '0;
  logic [63:0] tbv = '0;
  logic        tci = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // configurations under test
  logic [63:0] s64f, s64r;
  logic [31:0] s32f, s32r;
  logic [15:0] s16f;
  logic co64f, co64r, co32f, co32r, co16f;
  logic gg64f, gg64r, gg32f, gg32r, gg16f;
  logic gp64f, gp64r, gp32f, gp32r, gp16f;

  cla_adder #(.WIDTH(64)) i_cla_adder (
    .a(ta), .b(tbv), .cin(tci), .sum(s64f), .cout(co64f),
    .grp_gen_n(gg64f), .grp_prop_n(gp64f));

  cla_adder #(.WIDTH(64), .MODE(cla_pkg::TREE_BLOCK_RIPPLE)) i_cla_adder_w64r (
    .a(ta), .b(tbv), .cin(tci), .sum(s64r), .cout(co64r),
    .grp_gen_n(gg64r), .grp_prop_n(gp64r));

  cla_adder #(.WIDTH(32)) i_cla_adder_w32 (
    .a(ta[31:0]), .b(tbv[31:0]), .cin(tci), .sum(s32f), .cout(co32f),
    .grp_gen_n(gg32f), .grp_prop_n(gp32f));

  cla_adder #(.WIDTH(32), .MODE(cla_pkg::TREE_BLOCK_RIPPLE)) i_cla_adder_w32r (
    .a(ta[31:0]), .b(tbv[31:0]), .cin(tci), .sum(s32r), .cout(co32r),
    .grp_gen_n(gg32r), .grp_prop_n(gp32r));

  cla_adder #(.WIDTH(16)) i_cla_adder_w16 (
    .a(ta[15:0]), .b(tbv[15:0]), .cin(tci), .sum(s16f), .cout(co16f),
    .grp_gen_n(gg16f), .grp_prop_n(gp16f));

  // single look-ahead cell
  logic [3:0] cg_n = 4'hF;
  logic [3:0] cp_n = 4'hF;
  logic       c_ci = 1'b0;
  logic [2:0] c_car;
  logic       c_gg, c_gp;

  cla_cell #(.RADIX(4)) i_cell (
    .g_n(cg_n), .p_n(cp_n), .c_in(c_ci), .carry(c_car),
    .grp_g_n(c_gg), .grp_p_n(c_gp));

  function automatic logic [63:0] wmask(input int w);
    return (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [64:0] ref_add(input int w, input logic [63:0] x,
                                          input logic [63:0] y, input logic c);
    logic [64:0] xm, ym;
    xm = {1'b0, x & wmask(w)};
    ym = {1'b0, y & wmask(w)};
    return xm + ym + {64'd0, c};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_cfg(input string name, input int w, input string rs,
                           input string rg, input logic [63:0] s,
                           input logic co, input logic gg, input logic gp);
    logic [64:0] full, zero;
    logic [63:0] m;
    logic eg, ep, ec;
    m    = wmask(w);
    full = ref_add(w, ta, tbv, tci);
    zero = ref_add(w, ta, tbv, 1'b0);
    ec   = full[w];
    eg   = ~zero[w];
    ep   = ~(((ta ^ tbv) & m) == m);
    chk(s == (full[63:0] & m), rs, {name, " sum (R1)"}, s, full[63:0] & m);
    chk(co == ec, rs, {name, " cout (R2)"}, {63'd0, co}, {63'd0, ec});
    chk(gp == ep, rg, {name, " grp_prop_n (R3)"}, {63'd0, gp}, {63'd0, ep});
    chk(gg == eg, rg, {name, " grp_gen_n (R4)"}, {63'd0, gg}, {63'd0, eg});
    chk(co == (~gg | (~gp & tci)), "R5", {name, " cout from group pair"},
        {63'd0, co}, {63'd0, (~gg | (~gp & tci))});
  endtask

  task automatic check_all();
    check_cfg("w64 full",   64, "R1", "R3", s64f, co64f, gg64f, gp64f);
    check_cfg("w64 ripple", 64, "R7", "R7", s64r, co64r, gg64r, gp64r);
    check_cfg("w32 full",   32, "R8", "R8", {32'd0, s32f}, co32f, gg32f, gp32f);
    check_cfg("w32 ripple", 32, "R7", "R8", {32'd0, s32r}, co32r, gg32r, gp32r);
    check_cfg("w16 full",   16, "R1", "R4", {48'd0, s16f}, co16f, gg16f, gp16f);
  endtask

  task automatic run_vec(input logic [63:0] va, input logic [63:0] vb, input logic vc);
    @(posedge clk);
    ta  = va;
    tbv = vb;
    tci = vc;
    @(negedge clk);
    check_all();
  endtask

  // R6: full-length propagate chain
  task automatic chain(input logic [63:0] r, input logic vc);
    run_vec(r, ~r, vc);
    if (vc) begin
      chk(s64f == 64'd0 && co64f, "R6", "chain w64 full cin=1", s64f, 64'd0);
      chk(s64r == 64'd0 && co64r, "R6", "chain w64 ripple cin=1", s64r, 64'd0);
      chk(s32f == 32'd0 && co32f, "R6", "chain w32 cin=1", {32'd0, s32f}, 64'd0);
    end else begin
      chk(s64f == '1 && !co64f, "R6", "chain w64 full cin=0", s64f, '1);
      chk(s64r == '1 && !co64r, "R6", "chain w64 ripple cin=0", s64r, '1);
      chk(s16f == '1 && !co16f, "R6", "chain w16 cin=0", {48'd0, s16f}, 64'hFFFF);
    end
  endtask

  task automatic cell_sweep();
    for (int v = 0; v < 512; v++) begin
      logic [3:0] g, p;
      logic c, ex, ey, ez, eg, ep;
      @(posedge clk);
      cg_n = v[3:0];
      cp_n = v[7:4];
      c_ci = v[8];
      @(negedge clk);
      g  = ~cg_n;
      p  = ~cp_n;
      c  = c_ci;
      ex = g[0] | (p[0] & c);
      ey = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c);
      ez = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & c);
      eg = ~(g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0]));
      ep = ~(&p);
      chk(c_car == {ez, ey, ex}, "R9", "cell carries", {61'd0, c_car}, {61'd0, ez, ey, ex});
      chk(c_gg == eg && c_gp == ep, "R9", "cell group pair",
          {62'd0, c_gg, c_gp}, {62'd0, eg, ep});
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // state after start with all-zero inputs
    @(negedge clk);
    chk(s64f == 64'd0 && !co64f, "R1", "idle sum/cout", s64f, 64'd0);
    chk(gg64f && gp64f, "R3", "idle group pair", {62'd0, gg64f, gp64f}, 64'd3);
    check_all();

    // directed corners
    run_vec('1, 64'd0, 1'b1);
    run_vec('1, '1, 1'b0);
    run_vec('1, '1, 1'b1);
    run_vec(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1);
    run_vec(64'h8000_0000_8000_8000, 64'h8000_0000_8000_8000, 1'b0);
    run_vec(64'h0000_0000_0000_000F, 64'h0000_0000_0000_0001, 1'b0);
    chain(64'd0, 1'b1);
    chain(64'd0, 1'b0);
    for (int i = 0; i < 20; i++) begin
      chain({$urandom, $urandom}, i[0]);
    end

    // propagate chain broken at one position: group must not propagate
    for (int i = 0; i < 64; i += 7) begin
      logic [63:0] r;
      r = {$urandom, $urandom};
      run_vec(r, ~r ^ (64'd1 << i), 1'b1);
    end

    // random vectors
    for (int i = 0; i < 400; i++) begin
      run_vec({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
    end

    cell_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule